// File: doc/BRIEF.md
# Double-Buffered Memory-to-Memory DMA Channel Sequencer

This block is the control core of one memory-to-memory DMA channel. Software loads two descriptor slots, each holding a source address, a destination address and a byte length. Writing a slot marks it valid. Once the channel is enabled, the sequencer waits in a parked state. It leaves that state when a trigger arrives and the active slot is valid. A trigger is a software start pulse, a peripheral request or a transmit request. The sequencer then moves one 32-bit word at a time through a simple memory port: a read request, then a write request, then a length check. When a slot finishes, it retires that slot, flips to the other slot and parks again. On that completion it sets the done and park interrupt flags.

The memory port is a pair of level requests with one-cycle completion pulses. Arbitration and real memory timing sit outside the block. A device end-of-transfer input cuts the current slot short after the word in flight.

Top module: `dma_m2m_ctrl`

## Requirements
- R1: Out of reset, `phase` reads 0 (idle), both memory requests are low, `active_slot` is 0, and both flags and `irq` are low. The phase codes are 0 idle, 1 parked, 2 read, 3 write and 4 check.
- R2: When `chan_en` is low at a clock edge, the next cycle shows phase 0 and `active_slot` 0, and the length counter is cleared. No flag is set by this.
- R3: When `chan_en` is high in idle, the next phase is parked (1), and neither flag is set by this move.
- R4: In the parked state, a read starts only on a cycle where `sw_start`, `dev_req` or `tx_req` is high and the active slot is valid. Otherwise the phase stays 1.
- R5: `rd_req` stays high in phase 2 until `rd_done` arrives, and `wr_req` stays high in phase 3 until `wr_done` arrives. Each word goes read, then write, then check.
- R6: Word k of a slot reads from source+4k and writes to destination+4k. The slot ends at the check after the transferred count first reaches or passes the programmed length, so a length of 10 moves 3 words.
- R7: On slot completion the phase returns to 1. `flag_done` sets if `irq_en_done` is high and `flag_stall` sets if `irq_en_stall` is high.
- R8: A `dev_eot` pulse seen during read, write or check ends the slot after the word in flight completes.
- R9: On completion the finished slot becomes invalid and `active_slot` toggles. If the new slot is invalid, the phase stays parked even while requests are held high.
- R10: Flags stay set until a one-cycle pulse on `irq_clr_done` or `irq_clr_stall` clears them. `irq` is high while any flag is set together with its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; low forces idle |
| sw_start | input | 1 | Software start pulse |
| dev_req | input | 1 | Peripheral request |
| tx_req | input | 1 | Transmit request |
| dev_eot | input | 1 | Device end-of-transfer |
| slot_wr | input | 1 | Descriptor write strobe; sets that slot valid |
| slot_sel | input | 1 | Descriptor slot written |
| slot_src | input | ADDR_W | Source address to load |
| slot_dst | input | ADDR_W | Destination address to load |
| slot_len | input | CNT_W | Byte length to load |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Read address |
| rd_done | input | 1 | Read completion |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | ADDR_W | Write address |
| wr_done | input | 1 | Write completion |
| active_slot | output | 1 | Slot currently in use |
| phase | output | 3 | Sequencer state code |
| irq_en_done | input | 1 | Done interrupt enable |
| irq_en_stall | input | 1 | Park interrupt enable |
| irq_clr_done | input | 1 | Clear pulse for done flag |
| irq_clr_stall | input | 1 | Clear pulse for park flag |
| flag_done | output | 1 | Sticky done flag |
| flag_stall | output | 1 | Sticky park flag |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with 16-bit addresses, a 10-bit length field and the reach-or-pass length compare. These values keep the expected addresses easy to read. A 400-byte slot still fits, so a long transfer can be cut off by disable. A length of 10 brings the non-multiple-of-four rounding case within reach. The exact-compare variant is not built, because lengths that are not multiples of four would never finish under it.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_STALL = 3'd1,
      ST_RD    = 3'd2,
      ST_WR    = 3'd3,
      ST_CHECK = 3'd4
   } dmac_state_e;
endpackage

// File: rtl/dmac_slot_bank.sv
module dmac_slot_bank #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [ADDR_W-1:0] wr_src,
   input  logic [ADDR_W-1:0] wr_dst,
   input  logic [CNT_W-1:0]  wr_len,
   input  logic              retire,
   output logic              act_sel,
   output logic              act_valid,
   output logic [ADDR_W-1:0] act_src,
   output logic [ADDR_W-1:0] act_dst,
   output logic [CNT_W-1:0]  act_len
);
   localparam int NSLOT = 2;

   logic [NSLOT-1:0][ADDR_W-1:0] src_q;
   logic [NSLOT-1:0][ADDR_W-1:0] dst_q;
   logic [NSLOT-1:0][CNT_W-1:0]  len_q;
   logic [NSLOT-1:0]             vld_q;
   logic                         sel_q;

   // descriptor storage; a software write wins over a retire of the same slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
         dst_q <= '0;
         len_q <= '0;
         vld_q <= '0;
      end else begin
         for (int i = 0; i < NSLOT; i++) begin
            if (wr_en && (wr_sel == 1'(i))) begin
               src_q[i] <= wr_src;
               dst_q[i] <= wr_dst;
               len_q[i] <= wr_len;
               vld_q[i] <= 1'b1;
            end else if (retire && (sel_q == 1'(i))) begin
               vld_q[i] <= 1'b0;
            end
         end
      end
   end

   // ping-pong pointer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sel_q <= 1'b0;
      else if (!chan_en) sel_q <= 1'b0;
      else if (retire)   sel_q <= ~sel_q;
   end

   assign act_sel   = sel_q;
   assign act_valid = vld_q[sel_q];
   assign act_src   = src_q[sel_q];
   assign act_dst   = dst_q[sel_q];
   assign act_len   = len_q[sel_q];
endmodule

// File: rtl/dmac_seq_fsm.sv
module dmac_seq_fsm
   import dmac_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int STEP      = 4,
   parameter bit EXACT_CMP = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           chan_en,
   input  logic           trig,
   input  logic           act_valid,
   input  logic [CNT_W-1:0] act_len,
   input  logic           rd_done,
   input  logic           wr_done,
   input  logic           eot,
   output dmac_state_e    state,
   output logic [CNT_W:0] xfer_cnt,
   output logic           retire
);
   localparam int CW = CNT_W + 1;

   dmac_state_e   state_q, state_d;
   logic [CW-1:0] cnt_q;
   logic          eot_q;
   logic          reached;
   logic          finish;

   generate
      if (EXACT_CMP) begin : g_cmp_eq
         assign reached = (cnt_q == {1'b0, act_len});
      end else begin : g_cmp_ge
         assign reached = (cnt_q >= {1'b0, act_len});
      end
   endgenerate

   assign finish = reached || eot_q || eot;

   always_comb begin
      state_d = state_q;
      retire  = 1'b0;
      if (!chan_en) begin
         state_d = ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE:  state_d = ST_STALL;
            ST_STALL: if (trig && act_valid) state_d = ST_RD;
            ST_RD:    if (rd_done) state_d = ST_WR;
            ST_WR:    if (wr_done) state_d = ST_CHECK;
            ST_CHECK: begin
               if (finish) begin
                  state_d = ST_STALL;
                  retire  = 1'b1;
               end else begin
                  state_d = ST_RD;
               end
            end
            default:  state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (!chan_en || retire)        cnt_q <= '0;
      else if (state_q == ST_WR && wr_done) cnt_q <= cnt_q + CW'(STEP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  eot_q <= 1'b0;
      else if (!chan_en || retire) eot_q <= 1'b0;
      else if (eot && (state_q == ST_RD || state_q == ST_WR || state_q == ST_CHECK))
         eot_q <= 1'b1;
   end

   assign state    = state_q;
   assign xfer_cnt = cnt_q;
endmodule

// File: rtl/dmac_irq_flags.sv
module dmac_irq_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic retire,
   input  logic en_done,
   input  logic en_stall,
   input  logic clr_done,
   input  logic clr_stall,
   output logic flag_done,
   output logic flag_stall,
   output logic irq
);
   logic done_q, stall_q;

   // set has priority over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         stall_q <= 1'b0;
      end else begin
         if (retire && en_done)  done_q <= 1'b1;
         else if (clr_done)      done_q <= 1'b0;
         if (retire && en_stall) stall_q <= 1'b1;
         else if (clr_stall)     stall_q <= 1'b0;
      end
   end

   assign flag_done  = done_q;
   assign flag_stall = stall_q;
   assign irq        = (done_q & en_done) | (stall_q & en_stall);
endmodule

// File: rtl/dma_m2m_ctrl.sv
module dma_m2m_ctrl
   import dmac_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 16,
   parameter int DATA_W    = 32,
   parameter bit EXACT_CMP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic              sw_start,
   input  logic              dev_req,
   input  logic              tx_req,
   input  logic              dev_eot,
   input  logic              slot_wr,
   input  logic              slot_sel,
   input  logic [ADDR_W-1:0] slot_src,
   input  logic [ADDR_W-1:0] slot_dst,
   input  logic [CNT_W-1:0]  slot_len,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_done,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_done,
   output logic              active_slot,
   output logic [2:0]        phase,
   input  logic              irq_en_done,
   input  logic              irq_en_stall,
   input  logic              irq_clr_done,
   input  logic              irq_clr_stall,
   output logic              flag_done,
   output logic              flag_stall,
   output logic              irq
);
   localparam int WORD_BYTES = DATA_W / 8;
   localparam int CW         = CNT_W + 1;

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be a whole number of bytes");
      end
      if (ADDR_W < CW) begin : g_bad_addr
         $error("ADDR_W must exceed CNT_W");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W too small");
      end
   endgenerate

   logic              act_valid;
   logic [ADDR_W-1:0] act_src, act_dst;
   logic [CNT_W-1:0]  act_len;
   logic              retire;
   logic [CW-1:0]     xfer_cnt;
   dmac_state_e       state;

   dmac_slot_bank #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
      .wr_en(slot_wr), .wr_sel(slot_sel), .wr_src(slot_src),
      .wr_dst(slot_dst), .wr_len(slot_len), .retire(retire),
      .act_sel(active_slot), .act_valid(act_valid), .act_src(act_src),
      .act_dst(act_dst), .act_len(act_len)
   );

   dmac_seq_fsm #(.CNT_W(CNT_W), .STEP(WORD_BYTES), .EXACT_CMP(EXACT_CMP)) u_fsm (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
      .trig(sw_start | dev_req | tx_req), .act_valid(act_valid),
      .act_len(act_len), .rd_done(rd_done), .wr_done(wr_done),
      .eot(dev_eot), .state(state), .xfer_cnt(xfer_cnt), .retire(retire)
   );

   dmac_irq_flags u_irq (
      .clk(clk), .rst_n(rst_n), .retire(retire),
      .en_done(irq_en_done), .en_stall(irq_en_stall),
      .clr_done(irq_clr_done), .clr_stall(irq_clr_stall),
      .flag_done(flag_done), .flag_stall(flag_stall), .irq(irq)
   );

   assign phase   = state;
   assign rd_req  = (state == ST_RD);
   assign wr_req  = (state == ST_WR);
   assign rd_addr = act_src + ADDR_W'(xfer_cnt);
   assign wr_addr = act_dst + ADDR_W'(xfer_cnt);
endmodule

// File: rtl/dma_m2m_ctrl_chk.sv
module dma_m2m_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       chan_en,
   input logic       sw_start,
   input logic       dev_req,
   input logic       tx_req,
   input logic       rd_req,
   input logic       rd_done,
   input logic       wr_req,
   input logic       wr_done,
   input logic [2:0] phase,
   input logic       flag_done,
   input logic       flag_stall
);
   assert_disable_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> (phase == 3'd0));

   assert_enable_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'd0) |=> (!$rose(flag_stall) && !$rose(flag_done)));

   assert_no_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'd1 && chan_en && !sw_start && !dev_req && !tx_req) |=> (phase != 3'd2));

   assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_done && chan_en) |=> rd_req);

   assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_done && chan_en) |=> wr_req);

   assert_done_on_check_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_done) |-> ($past(phase) == 3'd4 && phase == 3'd1));
endmodule

bind dma_m2m_ctrl dma_m2m_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .sw_start(sw_start),
   .dev_req(dev_req), .tx_req(tx_req), .rd_req(rd_req), .rd_done(rd_done),
   .wr_req(wr_req), .wr_done(wr_done), .phase(phase),
   .flag_done(flag_done), .flag_stall(flag_stall)
);

// File: tb/tb_dma_m2m_ctrl.sv
module tb_dma_m2m_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int CW = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chan_en = 0, sw_start = 0, dev_req = 0, tx_req = 0, dev_eot = 0;
   logic slot_wr = 0, slot_sel = 0;
   logic [AW-1:0] slot_src = '0, slot_dst = '0;
   logic [CW-1:0] slot_len = '0;
   logic rd_req, wr_req, rd_done = 0, wr_done = 0;
   logic [AW-1:0] rd_addr, wr_addr;
   logic active_slot;
   logic [2:0] phase;
   logic irq_en_done = 0, irq_en_stall = 0, irq_clr_done = 0, irq_clr_stall = 0;
   logic flag_done, flag_stall, irq;

   int checks = 0, fails = 0, words = 0;
   bit mem_hold = 0, finished = 0;
   logic [AW-1:0] last_rd;
   logic [2*AW-1:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_m2m_ctrl #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(32), .EXACT_CMP(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .sw_start(sw_start),
      .dev_req(dev_req), .tx_req(tx_req), .dev_eot(dev_eot),
      .slot_wr(slot_wr), .slot_sel(slot_sel), .slot_src(slot_src),
      .slot_dst(slot_dst), .slot_len(slot_len),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_done(wr_done),
      .active_slot(active_slot), .phase(phase),
      .irq_en_done(irq_en_done), .irq_en_stall(irq_en_stall),
      .irq_clr_done(irq_clr_done), .irq_clr_stall(irq_clr_stall),
      .flag_done(flag_done), .flag_stall(flag_stall), .irq(irq)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // memory responder and scoreboard monitor
   always @(negedge clk) begin
      if (rd_req && !rd_done && !mem_hold) begin
         last_rd = rd_addr;
         rd_done = 1'b1;
      end else begin
         rd_done = 1'b0;
      end
      if (wr_req && !wr_done && !mem_hold) begin
         wr_done = 1'b1;
         words++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R6", "unexpected word", int'(wr_addr), 0);
         end else begin
            logic [2*AW-1:0] e;
            e = exp_q.pop_front();
            check(last_rd == e[2*AW-1:AW], "R6", "read address", int'(last_rd), int'(e[2*AW-1:AW]));
            check(wr_addr == e[AW-1:0], "R6", "write address", int'(wr_addr), int'(e[AW-1:0]));
         end
      end else begin
         wr_done = 1'b0;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load(input logic sel, input int src, input int dst, input int len);
      @(negedge clk);
      slot_wr = 1; slot_sel = sel;
      slot_src = AW'(src); slot_dst = AW'(dst); slot_len = CW'(len);
      @(negedge clk);
      slot_wr = 0;
   endtask

   task automatic expect_words(input int src, input int dst, input int n);
      for (int k = 0; k < n; k++) exp_q.push_back({AW'(src + 4*k), AW'(dst + 4*k)});
   endtask

   task automatic wait_flag(input bit want_done, input string req);
      int n = 0;
      while (n < 300 && !(want_done ? flag_done : flag_stall)) begin
         @(negedge clk);
         n++;
      end
      check(n < 300, req, "completion seen", n, 0);
   endtask

   task automatic pulse_clear();
      @(negedge clk);
      irq_clr_done = 1; irq_clr_stall = 1;
      @(negedge clk);
      irq_clr_done = 0; irq_clr_stall = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      tick(3);
      // R1 reset state
      check(phase == 3'd0, "R1", "phase", phase, 0);
      check(!rd_req && !wr_req, "R1", "requests", {rd_req, wr_req}, 0);
      check(!flag_done && !flag_stall && !irq, "R1", "flags", {flag_done, flag_stall, irq}, 0);
      check(active_slot == 1'b0, "R1", "active slot", active_slot, 0);
      rst_n = 1;
      tick(1);
      irq_en_done = 1; irq_en_stall = 1; chan_en = 1;
      tick(1);
      // R3 enable parks without interrupts
      check(phase == 3'd1, "R3", "phase after enable", phase, 1);
      check(!flag_stall && !flag_done, "R3", "flags after enable", {flag_done, flag_stall}, 0);

      load(1'b0, 'h100, 'h200, 10);
      load(1'b1, 'h300, 'h400, 8);
      tick(3);
      check(phase == 3'd1, "R4", "no trigger stays parked", phase, 1);

      // R6 slot 0: length 10 -> 3 words
      words = 0;
      expect_words('h100, 'h200, 3);
      sw_start = 1; tick(1); sw_start = 0;
      check(phase == 3'd2, "R4", "start enters read", phase, 2);
      wait_flag(1'b1, "R7");
      check(words == 3, "R6", "words moved", words, 3);
      check(phase == 3'd1, "R7", "phase after completion", phase, 1);
      check(flag_stall && irq, "R7", "stall flag and irq", {flag_stall, irq}, 3);
      check(active_slot == 1'b1, "R9", "slot toggled", active_slot, 1);
      tick(2);
      check(flag_done, "R10", "flag sticky", flag_done, 1);
      pulse_clear();
      check(!flag_done && !flag_stall && !irq, "R10", "cleared", {flag_done, flag_stall, irq}, 0);

      // R9 slot 1 via held dev_req, then slot 0 invalid
      words = 0;
      expect_words('h300, 'h400, 2);
      dev_req = 1;
      wait_flag(1'b1, "R9");
      tick(5);
      check(words == 2, "R9", "slot 1 words", words, 2);
      check(phase == 3'd1, "R9", "parked on invalid slot", phase, 1);
      check(active_slot == 1'b0, "R9", "back to slot 0", active_slot, 0);
      dev_req = 0;
      pulse_clear();

      // R7 done enable off
      irq_en_done = 0;
      load(1'b0, 'h500, 'h600, 4);
      expect_words('h500, 'h600, 1);
      tx_req = 1; tick(1); tx_req = 0;
      wait_flag(1'b0, "R7");
      check(!flag_done, "R7", "done flag masked", flag_done, 0);
      check(irq, "R7", "irq from stall flag", irq, 1);
      pulse_clear();
      irq_en_done = 1;

      // R2 disable mid transfer
      load(1'b1, 'h700, 'h800, 400);
      expect_words('h700, 'h800, 100);
      sw_start = 1; tick(1); sw_start = 0;
      tick(10);
      chan_en = 0;
      tick(1);
      check(phase == 3'd0, "R2", "phase after disable", phase, 0);
      check(!rd_req && !wr_req, "R2", "requests after disable", {rd_req, wr_req}, 0);
      check(active_slot == 1'b0, "R2", "slot reset", active_slot, 0);
      check(!flag_done && !flag_stall, "R2", "no flags", {flag_done, flag_stall}, 0);
      exp_q.delete();
      chan_en = 1;
      tick(1);
      check(phase == 3'd1 && !flag_stall, "R3", "re-enable parks quietly", {phase, flag_stall}, 2);

      // R5 / R8: held read then device end-of-transfer
      load(1'b0, 'h900, 'hA00, 40);
      words = 0;
      expect_words('h900, 'hA00, 1);
      mem_hold = 1;
      sw_start = 1; tick(1); sw_start = 0;
      tick(3);
      check(phase == 3'd2 && rd_req, "R5", "read held", {phase, rd_req}, 5);
      dev_eot = 1; tick(1); dev_eot = 0;
      mem_hold = 0;
      wait_flag(1'b1, "R8");
      check(words == 1, "R8", "early end words", words, 1);
      check(phase == 3'd1 && active_slot == 1'b1, "R8", "parked on other slot",
            {phase, active_slot}, 3);

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule